// File: doc/BRIEF.md
# Processor Core Register and Stack Unit

This block keeps the architectural state of a small 8-bit Harvard processor core: an accumulator, an index register, a stack pointer and a flags register. The instruction decoder, ALU, program counter and RAM array live elsewhere. They drive this unit through write enables with data, a one-cycle accumulator/stack-pointer exchange, and push and pop requests. For each push or pop the unit returns the RAM byte address that the stack access must use.

The flags register is the only one of the four that is visible in register space. It answers at one fixed address whatever bank is selected; the bank bit is itself a flag that this unit only holds. Firmware can change the flags by writing that address, or with mask operations that AND or OR an 8-bit immediate into them. Only the interrupt-enable, zero, carry and bank-select bits are stored.

Top module: `regStackUnit`

## Requirements
- R1: While `rstN` is low, and after it is released, the accumulator, index and stack pointer read 0x00 and the flags read 0x02, which is the Zero flag set.
- R2: `accWe` loads `accWdata` and `idxWe` loads `idxWdata` at the next rising edge. `swapAccSp` exchanges the accumulator and the stack pointer at one edge. It overrides `accWe`, `spWe`, `pushReq` and `popReq`.
- R3: For the stack pointer the order is swap, then `spWe` (loads `spWdata`), then push, then pop. A push moves the stack pointer up by one and a pop moves it down by one. `stackAddr` shows the current stack pointer when a push is requested. It shows the stack pointer minus one when a pop is requested without a push.
- R4: The stack pointer wraps from 0xFF to 0x00 on a push and from 0x00 to 0xFF on a pop, and no overflow is signalled.
- R5: Flag bit 0 is interrupt enable, bit 1 is Zero, bit 2 is Carry and bit 4 is the I/O bank select. Bits 3, 5, 6 and 7 always read 0, whatever value is written to them.
- R6: A read strobe with `regAddr` equal to 0xF7 sets `regHit` and returns the flags on `regRdata` in the same cycle. Any other address, or no read strobe, gives `regHit` = 0 and `regRdata` = 0x00.
- R7: A write strobe with `regAddr` = 0xF7 loads `regWdata` into the flags at the next edge. A write to any other address changes none of the four registers.
- R8: A mask operation (`maskEn`) replaces the flags with flags AND `maskImm`. When `maskIsOr` is 1 it uses flags OR `maskImm` instead.
- R9: For the flags the order is mask operation, then register write to 0xF7, then the datapath update (`flagWe`, `flagWdata`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accWe | input | 1 | Accumulator load enable |
| accWdata | input | 8 | Accumulator load value |
| idxWe | input | 1 | Index load enable |
| idxWdata | input | 8 | Index load value |
| spWe | input | 1 | Stack pointer load enable |
| spWdata | input | 8 | Stack pointer load value |
| swapAccSp | input | 1 | Exchange accumulator and stack pointer |
| pushReq | input | 1 | Stack push request |
| popReq | input | 1 | Stack pop request |
| stackAddr | output | 8 | RAM byte address for the current stack access |
| flagWe | input | 1 | Datapath flag update enable |
| flagWdata | input | 8 | Datapath flag value |
| maskEn | input | 1 | Flag mask operation enable |
| maskIsOr | input | 1 | 1 = OR mask, 0 = AND mask |
| maskImm | input | 8 | Mask immediate |
| regAddr | input | 8 | Register-space address |
| regRd | input | 1 | Register-space read strobe |
| regWr | input | 1 | Register-space write strobe |
| regWdata | input | 8 | Register-space write data |
| regHit | output | 1 | Read decoded as the flags address |
| regRdata | output | 8 | Register-space read data |
| accOut | output | 8 | Accumulator value |
| idxOut | output | 8 | Index value |
| spOut | output | 8 | Stack pointer value |
| flagsOut | output | 8 | Flags value |

## Verification
`stackAddr`, `regHit` and `regRdata` are combinational and settle in the cycle their request is driven. The four register outputs take a new value at the first rising edge after the enable.

The bench drives every input on a falling edge and checks the combinational outputs 1 ns later, before the rising edge. It then checks the registers at the next falling edge against a model that it updates at the same point. The sweeps walk the stack pointer across both wrap points and exercise every register-space address for reads and writes. A long run of random mixed requests exercises every priority order.

// File: rtl/regStackPkg.sv
package regStackPkg;
  typedef enum logic [1:0] {ACC_HOLD, ACC_LOAD, ACC_SWAP} accSelT;
  typedef enum logic [2:0] {SP_HOLD, SP_INC, SP_DEC, SP_LOAD, SP_SWAP} spSelT;
  typedef enum logic [1:0] {FL_HOLD, FL_DP, FL_REG, FL_MASK} flagSelT;

  typedef struct packed {
    accSelT  accSel;
    logic    idxLoad;
    spSelT   spSel;
    flagSelT flagSel;
    logic    maskOr;
    logic    stackPop;
    logic    readHit;
  } strobeT;
endpackage

// File: rtl/regStackCtrl.sv
module regStackCtrl
  import regStackPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'hF7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accWe,
  input  logic              idxWe,
  input  logic              spWe,
  input  logic              swapAccSp,
  input  logic              pushReq,
  input  logic              popReq,
  input  logic              flagWe,
  input  logic              maskEn,
  input  logic              maskIsOr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regRd,
  input  logic              regWr,
  output strobeT            stb
);
  logic addrMatch;
  assign addrMatch = (regAddr == FLAG_ADDR);

  always_comb begin
    stb = '0;
    stb.accSel  = ACC_HOLD;
    stb.spSel   = SP_HOLD;
    stb.flagSel = FL_HOLD;

    if (swapAccSp)  stb.accSel = ACC_SWAP;
    else if (accWe) stb.accSel = ACC_LOAD;

    stb.idxLoad = idxWe;

    if (swapAccSp)    stb.spSel = SP_SWAP;
    else if (spWe)    stb.spSel = SP_LOAD;
    else if (pushReq) stb.spSel = SP_INC;
    else if (popReq)  stb.spSel = SP_DEC;

    stb.stackPop = popReq && !pushReq;

    if (maskEn)                  stb.flagSel = FL_MASK;
    else if (regWr && addrMatch) stb.flagSel = FL_REG;
    else if (flagWe)             stb.flagSel = FL_DP;

    stb.maskOr  = maskIsOr;
    stb.readHit = regRd && addrMatch;
  end

  AST_MASK_WINS: assert property (@(posedge clk) disable iff (!rstN)
    maskEn |-> stb.flagSel == FL_MASK); // R9
  AST_SWAP_OVERRIDES: assert property (@(posedge clk) disable iff (!rstN)
    swapAccSp |-> (stb.spSel == SP_SWAP && stb.accSel == ACC_SWAP)); // R2
  AST_PUSH_OVER_POP: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && !swapAccSp && !spWe) |-> stb.spSel == SP_INC); // R3
endmodule

// File: rtl/regStackDp.sv
module regStackDp
  import regStackPkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] FLAG_RESET = 8'h02,
  parameter logic [DATA_W-1:0] FLAG_WMASK = 8'h17
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [DATA_W-1:0] accWdata,
  input  logic [DATA_W-1:0] idxWdata,
  input  logic [DATA_W-1:0] spWdata,
  input  logic [DATA_W-1:0] flagWdata,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] maskImm,
  output logic [DATA_W-1:0] acc,
  output logic [DATA_W-1:0] idx,
  output logic [DATA_W-1:0] sp,
  output logic [DATA_W-1:0] flags,
  output logic [DATA_W-1:0] stackAddr,
  output logic [DATA_W-1:0] regRdata
);
  localparam logic [DATA_W-1:0] ONE = 1;

  logic [DATA_W-1:0] accNext, spNext, flagsRaw, flagsNext;

  always_comb begin
    unique case (stb.accSel)
      ACC_LOAD: accNext = accWdata;
      ACC_SWAP: accNext = sp;
      default:  accNext = acc;
    endcase
  end

  always_comb begin
    unique case (stb.spSel)
      SP_INC:  spNext = sp + ONE;
      SP_DEC:  spNext = sp - ONE;
      SP_LOAD: spNext = spWdata;
      SP_SWAP: spNext = acc;
      default: spNext = sp;
    endcase
  end

  always_comb begin
    unique case (stb.flagSel)
      FL_MASK: flagsRaw = stb.maskOr ? (flags | maskImm) : (flags & maskImm);
      FL_REG:  flagsRaw = regWdata;
      FL_DP:   flagsRaw = flagWdata;
      default: flagsRaw = flags;
    endcase
    flagsNext = flagsRaw & FLAG_WMASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc   <= '0;
      idx   <= '0;
      sp    <= '0;
      flags <= FLAG_RESET;
    end else begin
      acc   <= accNext;
      sp    <= spNext;
      flags <= flagsNext;
      if (stb.idxLoad) idx <= idxWdata;
    end
  end

  assign stackAddr = stb.stackPop ? (sp - ONE) : sp;
  assign regRdata  = stb.readHit ? flags : '0;

  AST_SWAP_EXCH: assert property (@(posedge clk) disable iff (!rstN)
    stb.accSel == ACC_SWAP |=> (acc == $past(sp) && sp == $past(acc))); // R2
  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rstN)
    stb.spSel == SP_INC |=> sp == $past(sp) + ONE); // R4
  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    stb.spSel == SP_DEC |=> sp == $past(sp) - ONE); // R4
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (flags & ~FLAG_WMASK) == '0); // R5
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    stb.flagSel == FL_HOLD |=> $stable(flags)); // R7
endmodule

// File: rtl/regStackUnit.sv
module regStackUnit
  import regStackPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] FLAG_ADDR  = 8'hF7,
  parameter logic [DATA_W-1:0] FLAG_RESET = 8'h02,
  parameter logic [DATA_W-1:0] FLAG_WMASK = 8'h17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accWe,
  input  logic [DATA_W-1:0] accWdata,
  input  logic              idxWe,
  input  logic [DATA_W-1:0] idxWdata,
  input  logic              spWe,
  input  logic [DATA_W-1:0] spWdata,
  input  logic              swapAccSp,
  input  logic              pushReq,
  input  logic              popReq,
  output logic [DATA_W-1:0] stackAddr,
  input  logic              flagWe,
  input  logic [DATA_W-1:0] flagWdata,
  input  logic              maskEn,
  input  logic              maskIsOr,
  input  logic [DATA_W-1:0] maskImm,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWdata,
  output logic              regHit,
  output logic [DATA_W-1:0] regRdata,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] idxOut,
  output logic [DATA_W-1:0] spOut,
  output logic [DATA_W-1:0] flagsOut
);
  strobeT stb;

  regStackCtrl #(.ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR)) ctrl_i (
    .clk(clk), .rstN(rstN), .accWe(accWe), .idxWe(idxWe), .spWe(spWe),
    .swapAccSp(swapAccSp), .pushReq(pushReq), .popReq(popReq),
    .flagWe(flagWe), .maskEn(maskEn), .maskIsOr(maskIsOr),
    .regAddr(regAddr), .regRd(regRd), .regWr(regWr), .stb(stb)
  );

  regStackDp #(.DATA_W(DATA_W), .FLAG_RESET(FLAG_RESET), .FLAG_WMASK(FLAG_WMASK)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .accWdata(accWdata), .idxWdata(idxWdata), .spWdata(spWdata),
    .flagWdata(flagWdata), .regWdata(regWdata), .maskImm(maskImm),
    .acc(accOut), .idx(idxOut), .sp(spOut), .flags(flagsOut),
    .stackAddr(stackAddr), .regRdata(regRdata)
  );

  assign regHit = stb.readHit;

  AST_HIT_NEEDS_READ: assert property (@(posedge clk) disable iff (!rstN)
    regHit |-> regRd); // R6
endmodule

// File: tb/regStackUnit_tb_top.sv
`timescale 1ns/1ps
module regStackUnit_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accWe = 0, idxWe = 0, spWe = 0, swapAccSp = 0, pushReq = 0, popReq = 0;
  logic flagWe = 0, maskEn = 0, maskIsOr = 0, regRd = 0, regWr = 0;
  logic [7:0] accWdata = 0, idxWdata = 0, spWdata = 0, flagWdata = 0, maskImm = 0;
  logic [7:0] regAddr = 0, regWdata = 0;
  logic [7:0] stackAddr, regRdata, accOut, idxOut, spOut, flagsOut;
  logic regHit;

  int checks = 0;
  int errors = 0;
  logic [7:0] mAcc = 0, mIdx = 0, mSp = 0, mFlags = 8'h02;
  bit done = 0;

  always #10 clk = ~clk;

  regStackUnit dut_i (
    .clk(clk), .rstN(rstN), .accWe(accWe), .accWdata(accWdata), .idxWe(idxWe),
    .idxWdata(idxWdata), .spWe(spWe), .spWdata(spWdata), .swapAccSp(swapAccSp),
    .pushReq(pushReq), .popReq(popReq), .stackAddr(stackAddr), .flagWe(flagWe),
    .flagWdata(flagWdata), .maskEn(maskEn), .maskIsOr(maskIsOr), .maskImm(maskImm),
    .regAddr(regAddr), .regRd(regRd), .regWr(regWr), .regWdata(regWdata),
    .regHit(regHit), .regRdata(regRdata), .accOut(accOut), .idxOut(idxOut),
    .spOut(spOut), .flagsOut(flagsOut)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    accWe = 0; idxWe = 0; spWe = 0; swapAccSp = 0; pushReq = 0; popReq = 0;
    flagWe = 0; maskEn = 0; regRd = 0; regWr = 0;
  endtask

  // Called just after a falling edge with inputs driven.
  task automatic step();
    logic [7:0] nAcc, nIdx, nSp, nFlags, raw, expAddr;
    bit hit, wrapped;
    string spTag, flTag;
    #1;
    expAddr = (popReq && !pushReq) ? mSp - 8'd1 : mSp;
    if (pushReq || popReq) chk("R3 stackAddr", stackAddr, expAddr);
    hit = regRd && (regAddr == 8'hF7);
    chk("R6 regHit", {7'd0, regHit}, {7'd0, hit});
    chk("R6 regRdata", regRdata, hit ? mFlags : 8'h00);
    nAcc = swapAccSp ? mSp : (accWe ? accWdata : mAcc);
    nIdx = idxWe ? idxWdata : mIdx;
    wrapped = 0;
    if (swapAccSp) nSp = mAcc;
    else if (spWe) nSp = spWdata;
    else if (pushReq) begin nSp = mSp + 8'd1; wrapped = (mSp == 8'hFF); end
    else if (popReq) begin nSp = mSp - 8'd1; wrapped = (mSp == 8'h00); end
    else nSp = mSp;
    spTag = wrapped ? "R4 sp" : "R3 sp";
    if (maskEn) begin raw = maskIsOr ? (mFlags | maskImm) : (mFlags & maskImm); flTag = "R8 flags"; end
    else if (regWr && regAddr == 8'hF7) begin raw = regWdata; flTag = "R7 flags"; end
    else if (flagWe) begin raw = flagWdata; flTag = "R9 flags"; end
    else begin raw = mFlags; flTag = "R7 flags"; end
    nFlags = raw & 8'h17;
    @(posedge clk);
    mAcc = nAcc; mIdx = nIdx; mSp = nSp; mFlags = nFlags;
    @(negedge clk);
    chk(swapAccSp ? "R2 acc swap" : "R2 acc", accOut, mAcc);
    chk("R2 idx", idxOut, mIdx);
    chk(spTag, spOut, mSp);
    chk(flTag, flagsOut, mFlags);
    chk("R5 reserved", flagsOut & 8'hE8, 8'h00);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 acc", accOut, 8'h00);
    chk("R1 idx", idxOut, 8'h00);
    chk("R1 sp", spOut, 8'h00);
    chk("R1 flags", flagsOut, 8'h02);
    rstN = 1;
    @(negedge clk);
    chk("R1 flags after release", flagsOut, 8'h02);
    chk("R1 sp after release", spOut, 8'h00);

    // Push sweep across 0xFF->0x00 (R4), then pop sweep back across 0x00->0xFF.
    for (int i = 0; i < 260; i++) begin idle(); pushReq = 1; step(); end
    for (int i = 0; i < 270; i++) begin idle(); popReq = 1; step(); end
    idle(); pushReq = 1; popReq = 1; step(); // R3 push beats pop

    // Register-space sweep: read then write every address (R6, R7).
    for (int a = 0; a < 256; a++) begin
      idle(); regAddr = 8'(a); regRd = 1; step();
      idle(); regAddr = 8'(a); regWr = 1; regWdata = 8'(a) ^ 8'hFF; step();
    end

    // All mask immediates, both polarities (R8).
    for (int v = 0; v < 256; v++) begin
      idle(); maskEn = 1; maskIsOr = 1; maskImm = 8'(v); step();
      idle(); maskEn = 1; maskIsOr = 0; maskImm = 8'(v * 37 + 5); step();
    end

    // Priority collision: mask, register write and datapath together (R9).
    idle(); maskEn = 1; maskIsOr = 1; maskImm = 8'h01; regAddr = 8'hF7; regWr = 1;
    regWdata = 8'h00; flagWe = 1; flagWdata = 8'h00; step();
    idle(); regAddr = 8'hF7; regWr = 1; regWdata = 8'hFF; flagWe = 1; flagWdata = 8'h00; step();

    // Swap with competing writes (R2).
    idle(); accWe = 1; accWdata = 8'h5A; spWe = 1; spWdata = 8'hC3; step();
    idle(); swapAccSp = 1; accWe = 1; accWdata = 8'h11; spWe = 1; spWdata = 8'h22; pushReq = 1; step();

    // Random mixed traffic.
    for (int i = 0; i < 3000; i++) begin
      idle();
      accWe = 1'($urandom); idxWe = 1'($urandom); spWe = ($urandom % 5 == 0);
      swapAccSp = ($urandom % 7 == 0); pushReq = 1'($urandom); popReq = 1'($urandom);
      flagWe = 1'($urandom); maskEn = ($urandom % 4 == 0); maskIsOr = 1'($urandom);
      regRd = 1'($urandom); regWr = 1'($urandom);
      regAddr = ($urandom % 2) ? 8'hF7 : 8'($urandom);
      accWdata = 8'($urandom); idxWdata = 8'($urandom); spWdata = 8'($urandom);
      flagWdata = 8'($urandom); maskImm = 8'($urandom); regWdata = 8'($urandom);
      step();
    end

    idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule